// File: doc/BRIEF.md
# Paired-Block Interrupt Aggregator

This block collects interrupt sources for an eight-channel serial controller that is organised as four blocks of two channels each. Every block keeps an 8-bit status register, whose bits are set and cleared by one-cycle strobes from the channel logic, and an 8-bit enable mask that software loads over the register bus. Two neighbouring blocks share one interrupt line: a line rises when any enabled status bit of either block is set. This gives two lines for four blocks.

Software reaches the block over three small access spaces. The register space carries the per-block mask (written) and status (read) at the same offset. The identity space holds an 8-bit interrupt vector. The interrupt space returns that vector when the acknowledge address of a line is read. The status strobes come from channel logic outside this block. Within each block, a channel's bit positions depend on whether its number is even or odd.

The interrupt lines are registered. They follow the status and mask registers one clock later. Read data on both read ports is combinational and has no side effect.

Top module: `pair_irq_hub`

## Requirements
- R1: After synchronous reset, all status registers, all mask registers and the vector are zero, both interrupt lines are low, and both read ports return zero.
- R2: Channel n sits in block n/2. A set strobe for event kind k (0 = transmit ready, 1 = receive ready, 2 = break change) on channel n sets status bit k when n is even, and bit k+4 when n is odd. The strobe for channel n, kind k is `ch_set[3*n+k]`.
- R3: Block-level strobe `blk_set[2*b]` sets status bit 3 (counter ready) of block b, and `blk_set[2*b+1]` sets bit 7 (input-port change).
- R4: A clear strobe (`ch_clr`, `blk_clr`, same indexing as set) clears the addressed bit on the next edge. When set and clear hit the same bit in the same cycle, the bit ends up set.
- R5: A register-space write whose offset (the address bits 4:0 XOR 1) equals 0x0B loads the write data into the mask of block `io_addr[7:6]`. Writes at any other offset change no mask.
- R6: A register-space read at offset 0x0B returns the status of block `io_addr[7:6]`. Any other read offset, or no read, returns 0. Reads never change status.
- R7: Interrupt line k is high in the cycle after the status and mask registers of block 2k or block 2k+1 show a common set bit, and low in the cycle after neither does.
- R8: An identity-space write at address 1 loads the vector. Identity writes at other addresses are ignored.
- R9: An interrupt-space read at address 0 (line 0) or 2 (line 1) returns the vector. A read at any other address, or no read, returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | Register-space write strobe |
| io_rd | input | 1 | Register-space read strobe |
| io_addr | input | 8 | Register-space address (block in 7:6, channel in 7:5, offset in 4:0) |
| io_wdata | input | 8 | Register-space write data |
| io_rdata | output | 8 | Register-space read data, combinational |
| id_wr | input | 1 | Identity-space write strobe |
| id_addr | input | 8 | Identity-space address |
| id_wdata | input | 8 | Identity-space write data |
| ack_rd | input | 1 | Interrupt-space read (acknowledge) strobe |
| ack_addr | input | 8 | Interrupt-space address |
| ack_data | output | 8 | Acknowledge read data (vector or zero) |
| ch_set | input | 24 | Per-channel status set strobes, index 3*channel+kind |
| ch_clr | input | 24 | Per-channel status clear strobes, same indexing |
| blk_set | input | 8 | Per-block set strobes, index 2*block (counter) and 2*block+1 (input change) |
| blk_clr | input | 8 | Per-block clear strobes, same indexing |
| irq_line | output | 2 | Registered interrupt lines, bit k serves blocks 2k and 2k+1 |

## Verification
Two pairs of functions can land in the same cycle. First, a set strobe and a clear strobe can hit the same status bit together. The bench forces this on purpose and then reads the status back, expecting the bit to be set. Second, a mask write can arrive in the same cycle as status strobes for that block. The random phase produces this often, and the reference model judges the result in the order of edges: the register values update at the edge, and the line follows one edge later. It is compared on every clock against the line and both read ports.

// File: rtl/irqhub_pkg.sv
package irqhub_pkg;

    localparam int BYTE_W     = 8;
    localparam int EVT_PER_CH = 3;
    localparam int CH_PER_BLK = 2;
    localparam int BLK_EVT    = 2;
    localparam int ODD_SHIFT  = 4;
    localparam int BLK_PER_LINE = 2;

    localparam logic [4:0] STS_MSK_OFS = 5'h0B;
    localparam logic [7:0] VEC_ID_ADDR = 8'h01;

    typedef enum int unsigned {
        EV_TXRDY = 0,
        EV_RXRDY = 1,
        EV_BREAK = 2
    } ch_evt_e;

    typedef struct packed {
        logic sts_rd;
        logic msk_wr;
    } io_acc_t;

    function automatic int unsigned ch_bit_pos(input int unsigned ch_in_blk,
                                               input int unsigned kind);
        return kind + ch_in_blk * ODD_SHIFT;
    endfunction

    function automatic int unsigned blk_bit_pos(input int unsigned idx);
        return (idx == 0) ? 3 : 7;
    endfunction

    function automatic logic [4:0] reg_offset(input logic [4:0] low_bits);
        return low_bits ^ 5'h01;
    endfunction

endpackage

// File: rtl/irqhub_decode.sv
module irqhub_decode
    import irqhub_pkg::*;
#(
    parameter int AW   = 8,
    parameter int NBLK = 4,
    localparam int BW  = $clog2(NBLK),
    localparam int CW  = BW + 1
) (
    input  logic          io_wr,
    input  logic          io_rd,
    input  logic [AW-1:0] io_addr,
    output logic [BW-1:0] blk_sel,
    output io_acc_t       acc
);
    logic [CW-1:0] chan;
    logic [4:0]    ofs;
    logic          ch_parity_unused;

    assign chan             = io_addr[AW-1 -: CW];
    assign blk_sel          = chan[CW-1:1];
    assign ch_parity_unused = chan[0];
    assign ofs              = reg_offset(io_addr[4:0]);

    always_comb begin
        acc.sts_rd = io_rd && (ofs == STS_MSK_OFS);
        acc.msk_wr = io_wr && (ofs == STS_MSK_OFS);
    end
endmodule

// File: rtl/irqhub_bank.sv
module irqhub_bank
    import irqhub_pkg::*;
#(
    localparam int NEV = CH_PER_BLK * EVT_PER_CH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NEV-1:0]    ev_set,
    input  logic [NEV-1:0]    ev_clr,
    input  logic [BLK_EVT-1:0] bk_set,
    input  logic [BLK_EVT-1:0] bk_clr,
    input  logic              msk_we,
    input  logic [BYTE_W-1:0] msk_wdata,
    output logic [BYTE_W-1:0] sts_q,
    output logic [BYTE_W-1:0] msk_q
);
    logic [BYTE_W-1:0] set_v;
    logic [BYTE_W-1:0] clr_v;

    always_comb begin
        set_v = '0;
        clr_v = '0;
        for (int c = 0; c < CH_PER_BLK; c++) begin
            for (int k = 0; k < EVT_PER_CH; k++) begin
                set_v[ch_bit_pos(c, k)] = ev_set[c*EVT_PER_CH + k];
                clr_v[ch_bit_pos(c, k)] = ev_clr[c*EVT_PER_CH + k];
            end
        end
        for (int e = 0; e < BLK_EVT; e++) begin
            set_v[blk_bit_pos(e)] = bk_set[e];
            clr_v[blk_bit_pos(e)] = bk_clr[e];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sts_q <= '0;
            msk_q <= '0;
        end else begin
            sts_q <= (sts_q & ~clr_v) | set_v;
            if (msk_we) begin
                msk_q <= msk_wdata;
            end
        end
    end
endmodule

// File: rtl/irqhub_lines.sv
module irqhub_lines
    import irqhub_pkg::*;
#(
    parameter int NBLK   = 4,
    localparam int NLINE = NBLK / BLK_PER_LINE,
    localparam int SPAN  = BLK_PER_LINE * BYTE_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NBLK*BYTE_W-1:0] sts_flat,
    input  logic [NBLK*BYTE_W-1:0] msk_flat,
    output logic [NLINE-1:0]       irq_q
);
    for (genvar k = 0; k < NLINE; k++) begin : g_line
        logic hit;
        assign hit = |(sts_flat[k*SPAN +: SPAN] & msk_flat[k*SPAN +: SPAN]);

        always_ff @(posedge clk) begin
            if (rst) begin
                irq_q[k] <= 1'b0;
            end else begin
                irq_q[k] <= hit;
            end
        end
    end
endmodule

// File: rtl/irqhub_vector.sv
module irqhub_vector
    import irqhub_pkg::*;
#(
    parameter int NLINE = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              id_wr,
    input  logic [7:0]        id_addr,
    input  logic [BYTE_W-1:0] id_wdata,
    input  logic              ack_rd,
    input  logic [7:0]        ack_addr,
    output logic [BYTE_W-1:0] vec_q,
    output logic [BYTE_W-1:0] ack_data
);
    logic ack_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_q <= '0;
        end else if (id_wr && (id_addr == VEC_ID_ADDR)) begin
            vec_q <= id_wdata;
        end
    end

    assign ack_hit  = ack_rd && !ack_addr[0] && (int'(ack_addr[7:1]) < NLINE);
    assign ack_data = ack_hit ? vec_q : '0;
endmodule

// File: rtl/pair_irq_hub.sv
module pair_irq_hub
    import irqhub_pkg::*;
#(
    parameter int NBLK   = 4,
    parameter int AW     = 8,
    localparam int NCH   = NBLK * CH_PER_BLK,
    localparam int NLINE = NBLK / BLK_PER_LINE,
    localparam int BW    = $clog2(NBLK),
    localparam int NEV   = CH_PER_BLK * EVT_PER_CH
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   io_wr,
    input  logic                   io_rd,
    input  logic [AW-1:0]          io_addr,
    input  logic [BYTE_W-1:0]      io_wdata,
    output logic [BYTE_W-1:0]      io_rdata,
    input  logic                   id_wr,
    input  logic [7:0]             id_addr,
    input  logic [BYTE_W-1:0]      id_wdata,
    input  logic                   ack_rd,
    input  logic [7:0]             ack_addr,
    output logic [BYTE_W-1:0]      ack_data,
    input  logic [NCH*EVT_PER_CH-1:0] ch_set,
    input  logic [NCH*EVT_PER_CH-1:0] ch_clr,
    input  logic [NBLK*BLK_EVT-1:0] blk_set,
    input  logic [NBLK*BLK_EVT-1:0] blk_clr,
    output logic [NLINE-1:0]       irq_line
);
    logic [BW-1:0]          blk_sel;
    io_acc_t                acc;
    logic [BYTE_W-1:0]      sts_arr [NBLK];
    logic [BYTE_W-1:0]      msk_arr [NBLK];
    logic [NBLK*BYTE_W-1:0] sts_flat;
    logic [NBLK*BYTE_W-1:0] msk_flat;
    logic [BYTE_W-1:0]      vec_q;

    irqhub_decode #(.AW(AW), .NBLK(NBLK)) u_decode (
        .io_wr   (io_wr),
        .io_rd   (io_rd),
        .io_addr (io_addr),
        .blk_sel (blk_sel),
        .acc     (acc)
    );

    for (genvar b = 0; b < NBLK; b++) begin : g_blk
        irqhub_bank u_bank (
            .clk       (clk),
            .rst       (rst),
            .ev_set    (ch_set[b*NEV +: NEV]),
            .ev_clr    (ch_clr[b*NEV +: NEV]),
            .bk_set    (blk_set[b*BLK_EVT +: BLK_EVT]),
            .bk_clr    (blk_clr[b*BLK_EVT +: BLK_EVT]),
            .msk_we    (acc.msk_wr && (blk_sel == BW'(b))),
            .msk_wdata (io_wdata),
            .sts_q     (sts_arr[b]),
            .msk_q     (msk_arr[b])
        );
        assign sts_flat[b*BYTE_W +: BYTE_W] = sts_arr[b];
        assign msk_flat[b*BYTE_W +: BYTE_W] = msk_arr[b];
    end

    assign io_rdata = acc.sts_rd ? sts_arr[blk_sel] : '0;

    irqhub_lines #(.NBLK(NBLK)) u_lines (
        .clk      (clk),
        .rst      (rst),
        .sts_flat (sts_flat),
        .msk_flat (msk_flat),
        .irq_q    (irq_line)
    );

    irqhub_vector #(.NLINE(NLINE)) u_vector (
        .clk      (clk),
        .rst      (rst),
        .id_wr    (id_wr),
        .id_addr  (id_addr),
        .id_wdata (id_wdata),
        .ack_rd   (ack_rd),
        .ack_addr (ack_addr),
        .vec_q    (vec_q),
        .ack_data (ack_data)
    );
endmodule

// File: rtl/irqhub_checker.sv
module irqhub_checker #(
    parameter int NBLK  = 4,
    parameter int AW    = 8,
    parameter int NCH   = 8,
    parameter int NLINE = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 io_wr,
    input logic                 io_rd,
    input logic [AW-1:0]        io_addr,
    input logic [7:0]           io_wdata,
    input logic [7:0]           io_rdata,
    input logic                 id_wr,
    input logic [7:0]           id_addr,
    input logic [7:0]           id_wdata,
    input logic                 ack_rd,
    input logic [7:0]           ack_addr,
    input logic [7:0]           ack_data,
    input logic [NCH*3-1:0]     ch_set,
    input logic [NCH*3-1:0]     ch_clr,
    input logic [NBLK*8-1:0]    sts_flat,
    input logic [NBLK*8-1:0]    msk_flat,
    input logic [7:0]           vec_q,
    input logic [NLINE-1:0]     irq_line
);
    assert_quiet_after_reset_R1: assert property (@(posedge clk)
        $fell(rst) |-> (irq_line == '0 && vec_q == 8'h00 && sts_flat == '0));

    assert_odd_channel_bit_R2: assert property (@(posedge clk) disable iff (rst)
        ch_set[3] |=> sts_flat[4]);

    assert_set_beats_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (ch_set[0] && ch_clr[0]) |=> sts_flat[0]);

    assert_clear_drops_R4: assert property (@(posedge clk) disable iff (rst)
        (ch_clr[1] && !ch_set[1]) |=> !sts_flat[1]);

    assert_mask_load_R5: assert property (@(posedge clk) disable iff (rst)
        (io_wr && io_addr[4:0] == 5'h0A && io_addr[AW-1 -: 2] == 2'd0)
        |=> msk_flat[7:0] == $past(io_wdata));

    assert_other_offset_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (io_rd && io_addr[4:0] != 5'h0A) |-> io_rdata == 8'h00);

    for (genvar k = 0; k < NLINE; k++) begin : g_line_chk
        assert_line_follows_R7: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> irq_line[k] == $past(|(sts_flat[k*16 +: 16] & msk_flat[k*16 +: 16])));
    end

    assert_vector_load_R8: assert property (@(posedge clk) disable iff (rst)
        (id_wr && id_addr == 8'h01) |=> vec_q == $past(id_wdata));

    assert_ack_odd_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (ack_rd && ack_addr[0]) |-> ack_data == 8'h00);
endmodule

bind pair_irq_hub irqhub_checker #(
    .NBLK(NBLK), .AW(AW), .NCH(NCH), .NLINE(NLINE)
) u_irqhub_checker (
    .clk      (clk),
    .rst      (rst),
    .io_wr    (io_wr),
    .io_rd    (io_rd),
    .io_addr  (io_addr),
    .io_wdata (io_wdata),
    .io_rdata (io_rdata),
    .id_wr    (id_wr),
    .id_addr  (id_addr),
    .id_wdata (id_wdata),
    .ack_rd   (ack_rd),
    .ack_addr (ack_addr),
    .ack_data (ack_data),
    .ch_set   (ch_set),
    .ch_clr   (ch_clr),
    .sts_flat (sts_flat),
    .msk_flat (msk_flat),
    .vec_q    (vec_q),
    .irq_line (irq_line)
);

// File: tb/test_pair_irq_hub.sv
`timescale 1ns/1ps
module test_pair_irq_hub;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        io_wr = 0, io_rd = 0;
    logic [7:0]  io_addr = 0, io_wdata = 0, io_rdata;
    logic        id_wr = 0;
    logic [7:0]  id_addr = 0, id_wdata = 0;
    logic        ack_rd = 0;
    logic [7:0]  ack_addr = 0, ack_data;
    logic [23:0] ch_set = 0, ch_clr = 0;
    logic [7:0]  blk_set = 0, blk_clr = 0;
    logic [1:0]  irq_line;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [7:0] m_sts [4];
    logic [7:0] m_msk [4];
    logic [7:0] m_vec;
    logic [1:0] m_irq;

    always #10 clk = ~clk;

    pair_irq_hub i_pair_irq_hub (
        .clk(clk), .rst(rst),
        .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .id_wr(id_wr), .id_addr(id_addr), .id_wdata(id_wdata),
        .ack_rd(ack_rd), .ack_addr(ack_addr), .ack_data(ack_data),
        .ch_set(ch_set), .ch_clr(ch_clr), .blk_set(blk_set), .blk_clr(blk_clr),
        .irq_line(irq_line)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        io_wr = 0; io_rd = 0; io_addr = 0; io_wdata = 0;
        id_wr = 0; id_addr = 0; id_wdata = 0;
        ack_rd = 0; ack_addr = 0;
        ch_set = 0; ch_clr = 0; blk_set = 0; blk_clr = 0;
    endtask

    // Compare against the model, pass one clock edge, update the model.
    task automatic cycle();
        logic [7:0] exp_rd;
        logic [7:0] exp_ack;
        logic [1:0] nxt_irq;
        int bit_i;
        #1;
        exp_rd = (io_rd && ((io_addr[4:0] ^ 5'h01) == 5'h0B)) ? m_sts[io_addr[7:6]] : 8'h00;
        exp_ack = (ack_rd && (ack_addr == 8'd0 || ack_addr == 8'd2)) ? m_vec : 8'h00;
        chk("R6 model read data", io_rdata, exp_rd);
        chk("R7 model line", irq_line, m_irq);
        chk("R9 model ack data", ack_data, exp_ack);
        @(posedge clk);
        for (int k = 0; k < 2; k++)
            nxt_irq[k] = |((m_sts[2*k] & m_msk[2*k]) | (m_sts[2*k+1] & m_msk[2*k+1]));
        for (int ch = 0; ch < 8; ch++) begin
            for (int kind = 0; kind < 3; kind++) begin
                bit_i = kind + 4 * (ch % 2);
                if (ch_clr[3*ch+kind]) m_sts[ch/2][bit_i] = 1'b0;
                if (ch_set[3*ch+kind]) m_sts[ch/2][bit_i] = 1'b1;
            end
        end
        for (int b = 0; b < 4; b++) begin
            if (blk_clr[2*b])   m_sts[b][3] = 1'b0;
            if (blk_set[2*b])   m_sts[b][3] = 1'b1;
            if (blk_clr[2*b+1]) m_sts[b][7] = 1'b0;
            if (blk_set[2*b+1]) m_sts[b][7] = 1'b1;
        end
        if (io_wr && ((io_addr[4:0] ^ 5'h01) == 5'h0B)) m_msk[io_addr[7:6]] = io_wdata;
        if (id_wr && id_addr == 8'h01) m_vec = id_wdata;
        m_irq = nxt_irq;
        @(negedge clk);
    endtask

    task automatic peek_raw(input logic [7:0] a, output logic [7:0] v);
        io_rd = 1; io_addr = a;
        #1 v = io_rdata;
        cycle();
        io_rd = 0; io_addr = 0;
    endtask

    task automatic peek_ack(input logic [7:0] a, output logic [7:0] v);
        ack_rd = 1; ack_addr = a;
        #1 v = ack_data;
        cycle();
        ack_rd = 0; ack_addr = 0;
    endtask

    function automatic logic [7:0] sts_addr(input int b);
        return {b[1:0], 1'b0, 5'h0A};
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] v2;
        for (int b = 0; b < 4; b++) begin m_sts[b] = 0; m_msk[b] = 0; end
        m_vec = 0; m_irq = 0;
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1: reset state
        chk("R1 lines after reset", irq_line, 2'b00);
        peek_raw(sts_addr(0), v);  chk("R1 status block0 after reset", v, 8'h00);
        peek_ack(8'd0, v);         chk("R1 vector after reset", v, 8'h00);

        // R2: channel bit mapping (ch0 rx -> blk0 bit1, ch3 tx -> blk1 bit4, ch6 brk -> blk3 bit2)
        ch_set[3*0+1] = 1; ch_set[3*3+0] = 1; ch_set[3*6+2] = 1;
        cycle(); idle();
        peek_raw(sts_addr(0), v); chk("R2 block0 status", v, 8'h02);
        peek_raw(sts_addr(1), v); chk("R2 block1 status", v, 8'h10);
        peek_raw(sts_addr(2), v); chk("R2 block2 status", v, 8'h00);
        peek_raw(sts_addr(3), v); chk("R2 block3 status", v, 8'h04);

        // R3: block events on block 2
        blk_set[4] = 1; blk_set[5] = 1;
        cycle(); idle();
        peek_raw(sts_addr(2), v); chk("R3 block2 counter and input change", v, 8'h88);

        // R4: set and clear together on ch4 rx (blk2 bit1) -> set wins
        ch_set[13] = 1; ch_clr[13] = 1;
        cycle(); idle();
        peek_raw(sts_addr(2), v); chk("R4 set wins over clear", v, 8'h8A);
        ch_clr[13] = 1; blk_clr[4] = 1;
        cycle(); idle();
        peek_raw(sts_addr(2), v); chk("R4 clear alone", v, 8'h80);

        // R5: mask write to block1 enables its bit4 -> line 0
        io_wr = 1; io_addr = 8'h4A; io_wdata = 8'h10;
        cycle(); idle();
        cycle();
        chk("R5 mask write raises line0", irq_line[0], 1'b1);
        // write at offset 0x1B of block 2 must not load mask
        io_wr = 1; io_addr = 8'hBA; io_wdata = 8'hFF;
        cycle(); idle();
        cycle();
        chk("R5 other offset leaves mask", irq_line[1], 1'b0);

        // R7: line timing on block3 (status bit2 set)
        io_wr = 1; io_addr = 8'hCA; io_wdata = 8'h04;
        cycle(); idle();
        chk("R7 line not yet high after mask edge", irq_line[1], 1'b0);
        cycle();
        chk("R7 line high one edge later", irq_line[1], 1'b1);
        ch_clr[3*6+2] = 1;
        cycle(); idle();
        chk("R7 line still high after clear edge", irq_line[1], 1'b1);
        cycle();
        chk("R7 line low one edge later", irq_line[1], 1'b0);

        // R6: non-status offset returns 0, reads have no side effect
        peek_raw(8'h4B, v);       chk("R6 other offset reads zero", v, 8'h00);
        peek_raw(sts_addr(1), v);
        peek_raw(sts_addr(1), v2);
        chk("R6 first read", v, 8'h10);
        chk("R6 repeated read unchanged", v2, 8'h10);

        // R8 / R9: vector load and acknowledge
        id_wr = 1; id_addr = 8'h01; id_wdata = 8'hA5;
        cycle(); idle();
        peek_ack(8'd0, v);  chk("R8 vector via line0 ack", v, 8'hA5);
        id_wr = 1; id_addr = 8'h03; id_wdata = 8'h11;
        cycle(); idle();
        peek_ack(8'd2, v);  chk("R8 other id address ignored", v, 8'hA5);
        peek_ack(8'd2, v);  chk("R9 line1 ack returns vector", v, 8'hA5);
        peek_ack(8'd1, v);  chk("R9 odd ack address zero", v, 8'h00);
        peek_ack(8'd4, v);  chk("R9 ack address 4 zero", v, 8'h00);

        // Random phase, compared against the model every clock
        for (int i = 0; i < 4000; i++) begin
            ch_set  = 24'($urandom) & 24'($urandom) & 24'($urandom);
            ch_clr  = 24'($urandom) & 24'($urandom) & 24'($urandom);
            blk_set = 8'($urandom) & 8'($urandom) & 8'($urandom);
            blk_clr = 8'($urandom) & 8'($urandom) & 8'($urandom);
            io_addr = 8'($urandom);
            if ($urandom % 3 == 0) io_addr[4:0] = 5'h0A;
            io_wr    = ($urandom % 6 == 0);
            io_rd    = ($urandom % 2 == 0);
            io_wdata = 8'($urandom);
            id_wr    = ($urandom % 8 == 0);
            id_addr  = ($urandom % 2 == 0) ? 8'h01 : 8'($urandom);
            id_wdata = 8'($urandom);
            ack_rd   = ($urandom % 2 == 0);
            ack_addr = 8'($urandom % 5);
            cycle();
        end
        idle();
        cycle();

        done = 1;
        summary();
        $finish;
    end
endmodule